// File: doc/BRIEF.md
# Key-Sequence Protected Watchdog Timer

This block is a watchdog timer for a system controller. A counter advances on each timebase tick while the watchdog is enabled. If software does not restart it before it reaches the selected period, the watchdog either resets the system or raises an interrupt. A second missed period in interrupt mode turns into a reset. Software reaches the block through a 16-bit word bus with three addresses: the control register at 0, the low counter half at 1, and the high counter half at 2.

Two fixed key sequences guard the control register against stray writes. Loading new control bits takes the words 3333h and CCCCh, then the value. Restarting the counter takes AAAAh and then 5555h. All of these words are written to address 0 back to back. The reset output is a pulse of fixed length, and it returns every register to its disabled default.

Top module: `wdt_keyed_top`

## Requirements
- R1: After rst_ni is released, the control word reads 0000h, both counter halves read 0, and irq_o and wdt_rst_o are low.
- R2: A write to address 0 changes the control word only when it directly follows the writes 3333h and then CCCCh to address 0. Any other control write is ignored.
- R3: Control layout is as follows. Bit 15 is enable. Bit 14 selects the action: 1 = reset, 0 = interrupt. Bit 12 is the interrupt flag. Bits 7:0 are the timeout code. Bits 13 and 11:8 always read 0.
- R4: While enabled, the counter increments once per clock in which tick_i is high. While disabled, it holds 0. Address 1 returns bits 15:0 and address 2 returns bits 31:16.
- R5: Writing AAAAh and then 5555h to address 0 clears the counter and leaves the control word unchanged.
- R6: A write that breaks a sequence changes nothing and returns the tracker to idle. This includes a write to another address. Writes to addresses 1 and 2 have no effect.
- R7: In interrupt mode, the tick that brings the counter to the period does three things: it sets bit 12 and irq_o, it restarts the counter at 0, and it does not assert wdt_rst_o.
- R8: In interrupt mode, a second period with no feed after an interrupt timeout asserts wdt_rst_o. A feed in between prevents the reset.
- R9: wdt_rst_o is high for exactly RST_LEN clocks. It clears the control word, the flag, and the counter.
- R10: A keyed control write with bit 12 set clears the flag and irq_o. The same write with bit 12 clear leaves the flag set.
- R11: In reset mode, the tick that brings the counter to the period asserts wdt_rst_o.
- R12: A timeout code of zero, or one with more than one bit set, selects the shortest period, PER_SHORT ticks.
- R13: Code 01h gives PER_SHORT ticks. Code 02h gives PER_BASE ticks, and each higher bit doubles the period. Code 80h gives PER_BASE*64 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one clock wide |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Word address: 0 control, 1 count low, 2 count high |
| wdata_i | input | 16 | Bus write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt, follows the sticky flag |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
Reads are combinational from registers. A write or tick that a clock edge takes in is therefore visible on rdata_o, irq_o or wdt_rst_o in the cycle that follows that edge. The driver applies each write or tick for exactly one edge and lowers it just after. It then queues the expected value, and the monitor compares at the next falling edge, so every comparison lands one edge after its cause. The reset pulse is timed separately: a monitor counts the falling edges that see it high and compares the count with RST_LEN when the pulse ends.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = 2 * DATA_W;
  localparam int unsigned CODE_W = 8;

  localparam logic [DATA_W-1:0] KEY_UNLK_A = 16'h3333;
  localparam logic [DATA_W-1:0] KEY_UNLK_B = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_FEED_A = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_FEED_B = 16'h5555;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CNT_LO = 2'd1;
  localparam logic [1:0] ADDR_CNT_HI = 2'd2;

  localparam int unsigned BIT_EN   = 15;
  localparam int unsigned BIT_MODE = 14;
  localparam int unsigned BIT_FLAG = 12;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_UNLK1,
    SEQ_UNLK2,
    SEQ_FEED1
  } seq_state_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic              ctrl_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              load_o,
  output logic              feed_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    feed_o  = 1'b0;
    if (wr_i) begin
      // any write not continuing a sequence drops back to idle
      state_d = SEQ_IDLE;
      if (ctrl_sel_i) begin
        case (state_q)
          SEQ_IDLE: begin
            if (wdata_i == KEY_UNLK_A)      state_d = SEQ_UNLK1;
            else if (wdata_i == KEY_FEED_A) state_d = SEQ_FEED1;
          end
          SEQ_UNLK1: if (wdata_i == KEY_UNLK_B) state_d = SEQ_UNLK2;
          SEQ_UNLK2: load_o = 1'b1;
          SEQ_FEED1: if (wdata_i == KEY_FEED_B) feed_o = 1'b1;
          default:   state_d = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= SEQ_IDLE;
    else if (flush_i) state_q <= SEQ_IDLE;
    else              state_q <= state_d;
  end
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int unsigned PER_SHORT = 4,
  parameter int unsigned PER_BASE  = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  limit_o
);
  logic [CNT_W-1:0] tab [CODE_W];

  for (genvar g = 0; g < CODE_W; g++) begin : g_tab
    if (g == 0) begin : g_short
      assign tab[g] = CNT_W'(PER_SHORT);
    end else begin : g_dbl
      assign tab[g] = CNT_W'(PER_BASE) << (g - 1);
    end
  end

  always_comb begin
    limit_o = tab[0];
    if ($onehot(code_i)) begin
      for (int i = 0; i < CODE_W; i++) begin
        if (code_i[i]) limit_o = tab[i];
      end
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned RST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             rst_mode_i,
  input  logic             feed_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_evt_o,
  output logic             wipe_o,
  output logic             wdt_rst_o
);
  localparam int unsigned RST_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic [RST_W-1:0] pulse_q;
  logic             hit;

  // a feed in the same cycle as the terminal tick wins
  assign hit       = en_i && tick_i && !feed_i && ((cnt_q + CNT_W'(1)) >= limit_i);
  assign wipe_o    = hit && (rst_mode_i || pend_q);
  assign irq_evt_o = hit && !rst_mode_i && !pend_q;
  assign count_o   = cnt_q;
  assign wdt_rst_o = (pulse_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (wipe_o || !en_i || feed_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (hit) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pulse_q <= '0;
    else if (wipe_o)          pulse_q <= RST_W'(RST_LEN);
    else if (pulse_q != '0)   pulse_q <= pulse_q - RST_W'(1);
  end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int unsigned PER_SHORT = 4,
  parameter int unsigned PER_BASE  = 8,
  parameter int unsigned RST_LEN   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  logic              en_q, mode_q, flag_q;
  logic [CODE_W-1:0] code_q;
  logic              load, feed, wipe, irq_evt, bus_wr;
  logic [CNT_W-1:0]  limit, count;

  assign bus_wr = wr_en_i && !wdt_rst_o;

  wdt_key_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (wipe),
    .wr_i       (bus_wr),
    .ctrl_sel_i (addr_i == ADDR_CTRL),
    .wdata_i    (wdata_i),
    .load_o     (load),
    .feed_o     (feed)
  );

  wdt_period_sel #(
    .PER_SHORT (PER_SHORT),
    .PER_BASE  (PER_BASE)
  ) u_per (
    .code_i  (code_q),
    .limit_o (limit)
  );

  wdt_timer #(
    .RST_LEN (RST_LEN)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (en_q),
    .rst_mode_i (mode_q),
    .feed_i     (feed),
    .limit_i    (limit),
    .count_o    (count),
    .irq_evt_o  (irq_evt),
    .wipe_o     (wipe),
    .wdt_rst_o  (wdt_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      code_q <= '0;
    end else if (wipe) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      code_q <= '0;
    end else if (load) begin
      en_q   <= wdata_i[BIT_EN];
      mode_q <= wdata_i[BIT_MODE];
      code_q <= wdata_i[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         flag_q <= 1'b0;
    else if (wipe)                       flag_q <= 1'b0;
    else if (irq_evt)                    flag_q <= 1'b1;
    else if (load && wdata_i[BIT_FLAG])  flag_q <= 1'b0;
  end

  assign irq_o = flag_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[BIT_EN]       = en_q;
        rdata_o[BIT_MODE]     = mode_q;
        rdata_o[BIT_FLAG]     = flag_q;
        rdata_o[CODE_W-1:0]   = code_q;
      end
      ADDR_CNT_LO: rdata_o = count[DATA_W-1:0];
      ADDR_CNT_HI: rdata_o = count[CNT_W-1:DATA_W];
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_pkg::*;
#(
  parameter int unsigned RST_LEN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              wdt_rst_o,
  input logic              en_q,
  input logic              mode_q,
  input logic              flag_q,
  input logic [CODE_W-1:0] code_q,
  input logic [CNT_W-1:0]  count
);
  int unsigned width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        width_q <= 0;
    else if (wdt_rst_o) width_q <= width_q + 1;
    else                width_q <= 0;
  end

  // R9: pulse length
  a_r9_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> (width_q == RST_LEN));

  // R9: reset wipes state
  a_r9_wipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> (!en_q && !flag_q && count == '0));

  // R2: control moves only on a bus write to the control address
  a_r2_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable({en_q, mode_q, code_q}) && !wdt_rst_o) |-> $past(wr_en_i && addr_i == ADDR_CTRL));

  // R3: reserved bits read zero
  a_r3_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTRL) |-> (rdata_o[13] == 1'b0 && rdata_o[11:8] == 4'h0));

  // R4: counter held while disabled
  a_r4_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_q) |-> (count == '0));

  // R11: reset only follows a tick
  a_r11_tick_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(tick_i));

  // R7: interrupt raised at timeout in interrupt mode
  a_r7_irq_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (count == '0 && !mode_q && en_q));
endmodule

bind wdt_keyed_top wdt_keyed_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .wdt_rst_o (wdt_rst_o),
  .en_q      (en_q),
  .mode_q    (mode_q),
  .flag_q    (flag_q),
  .code_q    (code_q),
  .count     (count)
);

// File: tb/sim_wdt_keyed_top.sv
module sim_wdt_keyed_top;
  localparam int unsigned PER_SHORT = 4;
  localparam int unsigned PER_BASE  = 8;
  localparam int unsigned RST_LEN   = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;
  logic        irq_o, wdt_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int width = 0;

  typedef struct {
    int          sel;   // 0 rdata, 1 wdt_rst_o, 2 irq_o
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  always #5 clk_i = ~clk_i;

  wdt_keyed_top #(
    .PER_SHORT (PER_SHORT),
    .PER_BASE  (PER_BASE),
    .RST_LEN   (RST_LEN)
  ) u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .wdt_rst_o (wdt_rst_o)
  );

  // monitor: scoreboard compare
  always @(negedge clk_i) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sbq.pop_front();
      act = (it.sel == 0) ? rdata_o : (it.sel == 1) ? {15'h0, wdt_rst_o} : {15'h0, irq_o};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  // R9: pulse width monitor
  always @(negedge clk_i) begin
    if (wdt_rst_o) width++;
    else if (width != 0) begin
      n_chk++;
      if (width != RST_LEN) begin
        n_fail++;
        $display("FAIL R9: actual %0d expected %0d", width, RST_LEN);
      end
      width = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic ctrl(input logic [15:0] d);
    wr(2'd0, 16'h3333);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, d);
  endtask

  task automatic feed();
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h5555);
  endtask

  task automatic ticks(input int n);
    @(posedge clk_i); #1;
    tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    #1 tick_i = 1'b0;
  endtask

  task automatic chk(input int sel, input logic [1:0] a, input logic [15:0] e, input string r);
    @(posedge clk_i); #1;
    addr_i = a;
    sbq.push_back('{sel: sel, exp: e, req: r});
    @(negedge clk_i); #1;
  endtask

  task automatic settle();
    repeat (RST_LEN + 3) @(posedge clk_i);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    chk(0, 2'd0, 16'h0000, "R1 ctrl");
    chk(0, 2'd1, 16'h0000, "R1 cnt");
    chk(1, 2'd0, 16'h0000, "R1 rst");
    chk(2, 2'd0, 16'h0000, "R1 irq");

    wr(2'd0, 16'h8001);
    chk(0, 2'd0, 16'h0000, "R2 unkeyed");
    wr(2'd0, 16'h3333); wr(2'd0, 16'h1234); wr(2'd0, 16'h8001);
    chk(0, 2'd0, 16'h0000, "R2 broken key");

    ctrl(16'hAF02);
    chk(0, 2'd0, 16'h8002, "R3 reserved masked");

    ticks(5);
    chk(0, 2'd1, 16'h0005, "R4 count lo");
    chk(0, 2'd2, 16'h0000, "R4 count hi");

    feed();
    chk(0, 2'd1, 16'h0000, "R5 feed clears");
    chk(0, 2'd0, 16'h8002, "R5 ctrl kept");

    ticks(3);
    wr(2'd0, 16'hAAAA); wr(2'd0, 16'h1111); wr(2'd0, 16'h5555);
    chk(0, 2'd1, 16'h0003, "R6 broken feed");
    wr(2'd1, 16'h0000); wr(2'd2, 16'hFFFF);
    chk(0, 2'd1, 16'h0003, "R6 count write lo");
    chk(0, 2'd2, 16'h0000, "R6 count write hi");

    ticks(4);
    chk(2, 2'd0, 16'h0000, "R7 before period");
    ticks(1);
    chk(2, 2'd0, 16'h0001, "R7 irq");
    chk(0, 2'd1, 16'h0000, "R7 restart");
    chk(0, 2'd0, 16'h9002, "R7 flag");
    chk(1, 2'd0, 16'h0000, "R7 no reset");

    feed();
    ticks(8);
    chk(1, 2'd0, 16'h0000, "R8 fed no reset");
    ticks(7);
    chk(1, 2'd0, 16'h0000, "R8 early");
    ticks(1);
    chk(1, 2'd0, 16'h0001, "R8 escalate");
    settle();
    chk(0, 2'd0, 16'h0000, "R9 ctrl wiped");
    chk(2, 2'd0, 16'h0000, "R9 irq wiped");
    chk(0, 2'd1, 16'h0000, "R9 cnt wiped");

    ctrl(16'h8001);
    ticks(4);
    chk(0, 2'd0, 16'h9001, "R13 short period");
    ctrl(16'h8001);
    chk(0, 2'd0, 16'h9001, "R10 flag kept");
    ctrl(16'h9001);
    chk(0, 2'd0, 16'h8001, "R10 flag cleared");
    chk(2, 2'd0, 16'h0000, "R10 irq low");
    ctrl(16'h0000);

    ctrl(16'hC001);
    ticks(3);
    chk(1, 2'd0, 16'h0000, "R11 early");
    ticks(1);
    chk(1, 2'd0, 16'h0001, "R11 reset mode");
    settle();
    chk(0, 2'd0, 16'h0000, "R11 after reset");

    ctrl(16'hC003);
    ticks(3);
    chk(1, 2'd0, 16'h0000, "R12 multi-bit early");
    ticks(1);
    chk(1, 2'd0, 16'h0001, "R12 multi-bit");
    settle();
    ctrl(16'hC000);
    ticks(4);
    chk(1, 2'd0, 16'h0001, "R12 zero code");
    settle();

    ctrl(16'h8080);
    ticks(511);
    chk(0, 2'd1, 16'h01FF, "R13 long count");
    chk(2, 2'd0, 16'h0000, "R13 long early");
    ticks(1);
    chk(2, 2'd0, 16'h0001, "R13 long period");

    ctrl(16'h1080);
    ticks(3);
    chk(0, 2'd1, 16'h0000, "R4 disabled hold");
    chk(2, 2'd0, 16'h0000, "R10 clear on disable write");

    repeat (3) @(posedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule